// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block lets two processors exchange short messages. Each of the two ports, A and B, owns four outgoing mailboxes, each 16 bits wide. A port writes its own mailboxes one byte or two bytes at a time. A write that includes the upper byte raises a matching interrupt source toward the other port. The receiving port sees the message through a read-only window onto the sender's mailboxes. When it reads the upper byte of a mailbox in that window, the source clears. The message stays in place.

Each port also has a control word. The low nibble is a mask with one bit per source. The next nibble is the post-mask cause field and the nibble above it is the pre-mask status field. Both of these read active-low. The port's active-low interrupt line is asserted while any unmasked cause bit is set.

Accesses are synchronous. An access takes effect on the rising clock edge while the port's select is high. Read data is combinational from the current state and address, so it is valid before the edge that applies any side effect of the read.

Top module: `mbx_intc`

## Requirements
- R1: At offsets 0–3 a port writes its own mailbox 0–3. Lower-byte enable writes bits 7:0 and upper-byte enable writes bits 15:8. Reading the same offset returns the stored word from the cycle after the write.
- R2: A write to own mailbox i that includes the upper byte sets source i of the opposite port. That port's status bit 8+i then reads 0.
- R3: A port reading its own mailbox (offsets 0–3, any byte enables) leaves the interrupt state of the opposite port unchanged.
- R4: At offset 4+i a port reads the opposite port's mailbox i and gets its full word. If the upper-byte enable is 1, source i of the reading port clears in both cause and status, and the mailbox data is unchanged. A read with only the lower-byte enable clears nothing.
- R5: The control word at offset 8 reads as follows: bits 3:0 are the mask, bits 7:4 are the inverted cause bits, bits 11:8 are the inverted status bits, and bits 15:12 are 0.
- R6: A write to offset 8 with the lower-byte enable loads all four mask bits from write data bits 3:0. A mask bit of 1 disables its source. A write to offset 8 with only the upper-byte enable changes nothing. Each port's mask is its own.
- R7: A source that arrives while its mask bit is 1 sets status but not cause, and clearing the mask later does not create the cause bit. A cause bit is never set without its status bit.
- R8: The interrupt output is 0 while some cause bit whose mask bit is 0 is set, and 1 otherwise. Masking a pending cause releases it.
- R9: When the opposite port sets source i in the same cycle that the local port clears it, the set wins.
- R10: Writes to offsets 4–7 and 9–63 have no effect. Reads of offsets 9–63 return 0. Read data is 0 while select is low and during writes.
- R11: Synchronous reset clears all mailboxes, masks, causes and status bits. The control word then reads 16'h0FF0 and both interrupt outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aSel | input | 1 | Port A access select |
| aAddr | input | 6 | Port A offset |
| aWr | input | 1 | Port A write (1) or read (0) |
| aUb | input | 1 | Port A upper-byte enable |
| aLb | input | 1 | Port A lower-byte enable |
| aWdata | input | 16 | Port A write data |
| aRdata | output | 16 | Port A read data |
| aIntN | output | 1 | Port A interrupt, active low |
| bSel | input | 1 | Port B access select |
| bAddr | input | 6 | Port B offset |
| bWr | input | 1 | Port B write (1) or read (0) |
| bUb | input | 1 | Port B upper-byte enable |
| bLb | input | 1 | Port B lower-byte enable |
| bWdata | input | 16 | Port B write data |
| bRdata | output | 16 | Port B read data |
| bIntN | output | 1 | Port B interrupt, active low |

## Verification
The hardest case to reach is a collision on one source: the sender writes the upper byte of mailbox i in the same cycle that the receiver reads the upper byte of that mailbox through its window. The stimulus reaches it with a step that drives both ports in a single cycle, after first leaving the source pending. A second case that is hard to reach is a source that arrives while masked and is then unmasked. The bench reaches it by changing the mask between the sender's write and the receiver's control-word reads. A model of both ports predicts every read word and interrupt level.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Mailboxes owned by each port.
  localparam int MBX_NUM   = 4;
  localparam int MBX_IDX_W = $clog2(MBX_NUM);

  // What the read mux returns this cycle.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_OWN  = 2'd1,
    RD_PEER = 2'd2,
    RD_CTRL = 2'd3
  } rdKind_e;

  // Per-port strobes from the decoder to the datapath.
  typedef struct packed {
    logic [MBX_NUM-1:0]   wrLo;    // write lower byte of own mailbox
    logic [MBX_NUM-1:0]   wrHi;    // write upper byte of own mailbox
    logic [MBX_NUM-1:0]   ackHi;   // upper-byte read of peer mailbox
    logic                 wrMask;  // load mask nibble
    rdKind_e              rdKind;
    logic [MBX_IDX_W-1:0] rdIdx;
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              ub,
  input  logic              lb,
  output mbxStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] PEER_BASE = ADDR_W'(MBX_NUM);
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'(2 * MBX_NUM);

  logic [MBX_IDX_W-1:0] idx;
  assign idx = addr[MBX_IDX_W-1:0];

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    strb.rdIdx  = idx;
    if (sel) begin
      if (addr < PEER_BASE) begin
        if (wr) begin
          strb.wrLo[idx] = lb;
          strb.wrHi[idx] = ub;
        end else begin
          strb.rdKind = RD_OWN;
        end
      end else if (addr < CTRL_OFS) begin
        // Peer window is read-only; writes fall through with no strobe.
        if (!wr) begin
          strb.rdKind     = RD_PEER;
          strb.ackHi[idx] = ub;
        end
      end else if (addr == CTRL_OFS) begin
        if (wr) strb.wrMask = lb;
        else    strb.rdKind = RD_CTRL;
      end
    end
  end

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  mbxStrobe_t         strb    [2],
  input  logic [DATA_W-1:0]  wdata   [2],
  output logic [DATA_W-1:0]  rdata   [2],
  output logic [1:0]         intN,
  output logic [MBX_NUM-1:0] maskQ   [2],
  output logic [MBX_NUM-1:0] causeQ  [2],
  output logic [MBX_NUM-1:0] statusQ [2]
);

  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] mbxQ [2][MBX_NUM];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int OPP = 1 - p;

    logic [MBX_NUM-1:0] setEv;
    logic [MBX_NUM-1:0] ackEv;
    logic [MBX_NUM-1:0] maskR;
    logic [MBX_NUM-1:0] causeR;
    logic [MBX_NUM-1:0] statusR;
    logic [DATA_W-1:0]  ctrlWord;

    assign setEv = strb[OPP].wrHi;
    assign ackEv = strb[p].ackHi;

    for (genvar i = 0; i < MBX_NUM; i++) begin : g_box
      logic [DATA_W-1:0] boxQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          boxQ <= '0;
        end else begin
          if (strb[p].wrLo[i]) boxQ[BYTE_W-1:0]      <= wdata[p][BYTE_W-1:0];
          if (strb[p].wrHi[i]) boxQ[DATA_W-1:BYTE_W] <= wdata[p][DATA_W-1:BYTE_W];
        end
      end
      assign mbxQ[p][i] = boxQ;
    end

    // Set takes priority over a same-cycle acknowledge. The cause bit
    // uses the mask held before this edge.
    always_ff @(posedge clk) begin
      if (rst) begin
        maskR   <= '0;
        causeR  <= '0;
        statusR <= '0;
      end else begin
        if (strb[p].wrMask) maskR <= wdata[p][MBX_NUM-1:0];
        statusR <= setEv | (statusR & ~ackEv);
        causeR  <= (setEv & ~maskR) | (causeR & ~ackEv);
      end
    end

    always_comb begin
      ctrlWord                        = '0;
      ctrlWord[MBX_NUM-1:0]           = maskR;
      ctrlWord[2*MBX_NUM-1:MBX_NUM]   = ~causeR;
      ctrlWord[3*MBX_NUM-1:2*MBX_NUM] = ~statusR;
    end

    always_comb begin
      unique case (strb[p].rdKind)
        RD_OWN:  rdata[p] = mbxQ[p][strb[p].rdIdx];
        RD_PEER: rdata[p] = mbxQ[OPP][strb[p].rdIdx];
        RD_CTRL: rdata[p] = ctrlWord;
        default: rdata[p] = '0;
      endcase
    end

    assign intN[p]    = ~|(causeR & ~maskR);
    assign maskQ[p]   = maskR;
    assign causeQ[p]  = causeR;
    assign statusQ[p] = statusR;
  end

endmodule

// File: rtl/mbx_intc.sv
module mbx_intc
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aSel,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aWr,
  input  logic              aUb,
  input  logic              aLb,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aIntN,
  input  logic              bSel,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bWr,
  input  logic              bUb,
  input  logic              bLb,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bIntN
);

  logic               selArr  [2];
  logic [ADDR_W-1:0]  addrArr [2];
  logic               wrArr   [2];
  logic               ubArr   [2];
  logic               lbArr   [2];
  logic [DATA_W-1:0]  wdArr   [2];
  logic [DATA_W-1:0]  rdArr   [2];
  mbxStrobe_t         strb    [2];
  logic [1:0]         intN;
  logic [MBX_NUM-1:0] maskQ   [2];
  logic [MBX_NUM-1:0] causeQ  [2];
  logic [MBX_NUM-1:0] statusQ [2];

  assign selArr[0]  = aSel;   assign selArr[1]  = bSel;
  assign addrArr[0] = aAddr;  assign addrArr[1] = bAddr;
  assign wrArr[0]   = aWr;    assign wrArr[1]   = bWr;
  assign ubArr[0]   = aUb;    assign ubArr[1]   = bUb;
  assign lbArr[0]   = aLb;    assign lbArr[1]   = bLb;
  assign wdArr[0]   = aWdata; assign wdArr[1]   = bWdata;

  for (genvar p = 0; p < 2; p++) begin : g_ctrl
    mbx_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .sel  (selArr[p]),
      .addr (addrArr[p]),
      .wr   (wrArr[p]),
      .ub   (ubArr[p]),
      .lb   (lbArr[p]),
      .strb (strb[p])
    );
  end

  mbx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wdata   (wdArr),
    .rdata   (rdArr),
    .intN    (intN),
    .maskQ   (maskQ),
    .causeQ  (causeQ),
    .statusQ (statusQ)
  );

  assign aRdata = rdArr[0];
  assign bRdata = rdArr[1];
  assign aIntN  = intN[0];
  assign bIntN  = intN[1];

endmodule

// File: rtl/mbx_intc_chk.sv
module mbx_intc_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rst,
  input mbxStrobe_t         strb    [2],
  input logic [DATA_W-1:0]  wdata   [2],
  input logic [MBX_NUM-1:0] maskQ   [2],
  input logic [MBX_NUM-1:0] causeQ  [2],
  input logic [MBX_NUM-1:0] statusQ [2],
  input logic [1:0]         intN
);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    localparam int OPP = 1 - p;

    AST_ONE_BOX_WRITTEN: assert property (@(posedge clk) disable iff (rst)
      $onehot0(strb[p].wrHi) && $onehot0(strb[p].wrLo)); // R1

    AST_HI_WRITE_SETS: assert property (@(posedge clk) disable iff (rst)
      (strb[OPP].wrHi != '0) |=>
        ((statusQ[p] & $past(strb[OPP].wrHi)) == $past(strb[OPP].wrHi))); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ((strb[p].ackHi & ~strb[OPP].wrHi) != '0) |=>
        ((statusQ[p] & $past(strb[p].ackHi)) == '0)); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !strb[p].wrMask |=> $stable(maskQ[p])); // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
      strb[p].wrMask |=> (maskQ[p] == $past(wdata[p][MBX_NUM-1:0]))); // R6

    AST_CAUSE_NOT_MASKED: assert property (@(posedge clk) disable iff (rst)
      (causeQ[p] & ~$past(causeQ[p]) & $past(maskQ[p])) == '0); // R7

    AST_CAUSE_IN_STATUS: assert property (@(posedge clk) disable iff (rst)
      (causeQ[p] & ~statusQ[p]) == '0); // R7

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (maskQ[p] == '1) |-> intN[p]); // R8

    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
      ((strb[OPP].wrHi & strb[p].ackHi) != '0) |=>
        ((statusQ[p] & $past(strb[p].ackHi & strb[OPP].wrHi)) != '0)); // R9

    AST_RESET_CLEAN: assert property (@(posedge clk)
      rst |=> (statusQ[p] == '0 && causeQ[p] == '0 && maskQ[p] == '0 && intN[p])); // R11
  end

endmodule

bind mbx_intc mbx_intc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strb    (strb),
  .wdata   (wdArr),
  .maskQ   (maskQ),
  .causeQ  (causeQ),
  .statusQ (statusQ),
  .intN    (intN)
);

// File: tb/mbx_intc_bench.sv
`timescale 1ns/1ps
module mbx_intc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel  [2];
  logic [5:0]  addr [2];
  logic        wr   [2];
  logic        ub   [2];
  logic        lb   [2];
  logic [15:0] wd   [2];
  logic [15:0] rdA, rdB;
  logic        intNA, intNB;

  logic [15:0] mMbx  [2][4];
  logic [3:0]  mMask [2];
  logic [3:0]  mCause[2];
  logic [3:0]  mStat [2];
  logic [15:0] lastRd[2];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbx_intc u_mbx_intc (
    .clk(clk), .rst(rst),
    .aSel(sel[0]), .aAddr(addr[0]), .aWr(wr[0]), .aUb(ub[0]), .aLb(lb[0]),
    .aWdata(wd[0]), .aRdata(rdA), .aIntN(intNA),
    .bSel(sel[1]), .bAddr(addr[1]), .bWr(wr[1]), .bUb(ub[1]), .bLb(lb[1]),
    .bWdata(wd[1]), .bRdata(rdB), .bIntN(intNB)
  );

  task automatic checkVal(input string tag, input string what,
                          input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int p = 0; p < 2; p++) begin
      mMask[p] = '0; mCause[p] = '0; mStat[p] = '0;
      for (int i = 0; i < 4; i++) mMbx[p][i] = '0;
    end
  endtask

  function automatic logic [15:0] expRead(input int p);
    int a;
    a = int'(addr[p]);
    if (!sel[p] || wr[p]) return 16'h0;
    if (a < 4) return mMbx[p][a];
    if (a < 8) return mMbx[1-p][a-4];
    if (a == 8) return {4'h0, ~mStat[p], ~mCause[p], mMask[p]};
    return 16'h0;
  endfunction

  // Next state from the current stimulus, following the requirements.
  task automatic modelUpdate();
    logic [3:0] hiW [2];
    logic [3:0] ack [2];
    logic [3:0] oldMask [2];
    for (int p = 0; p < 2; p++) begin
      int a;
      a = int'(addr[p]);
      hiW[p] = '0; ack[p] = '0; oldMask[p] = mMask[p];
      if (sel[p] && wr[p] && a < 4) begin
        if (lb[p]) mMbx[p][a][7:0]  = wd[p][7:0];
        if (ub[p]) begin mMbx[p][a][15:8] = wd[p][15:8]; hiW[p][a] = 1'b1; end
      end
      if (sel[p] && wr[p] && lb[p] && a == 8) mMask[p] = wd[p][3:0];
      if (sel[p] && !wr[p] && ub[p] && a >= 4 && a < 8) ack[p][a-4] = 1'b1;
    end
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 4; i++) begin
        if (hiW[1-p][i]) mStat[p][i] = 1'b1;
        else if (ack[p][i]) mStat[p][i] = 1'b0;
        if (hiW[1-p][i] && !oldMask[p][i]) mCause[p][i] = 1'b1;
        else if (ack[p][i]) mCause[p][i] = 1'b0;
      end
    end
  endtask

  task automatic idleAll();
    for (int p = 0; p < 2; p++) begin
      sel[p] = 0; addr[p] = '0; wr[p] = 0; ub[p] = 0; lb[p] = 0; wd[p] = '0;
    end
  endtask

  // Called just after a falling edge with inputs set; returns at the next.
  task automatic step(input string tag);
    #1;
    lastRd[0] = rdA;
    lastRd[1] = rdB;
    checkVal(tag, "port A read", rdA, expRead(0));
    checkVal(tag, "port B read", rdB, expRead(1));
    modelUpdate();
    @(posedge clk);
    @(negedge clk);
    checkVal(tag, "port A intN", {15'h0, intNA}, {15'h0, ~|(mCause[0] & ~mMask[0])});
    checkVal(tag, "port B intN", {15'h0, intNB}, {15'h0, ~|(mCause[1] & ~mMask[1])});
  endtask

  task automatic setPort(input int p, input int a, input bit w, input bit u,
                         input bit l, input logic [15:0] d);
    sel[p] = 1; addr[p] = 6'(a); wr[p] = w; ub[p] = u; lb[p] = l; wd[p] = d;
  endtask

  task automatic op(input int p, input int a, input bit w, input bit u,
                    input bit l, input logic [15:0] d, input string tag);
    idleAll();
    setPort(p, a, w, u, l, d);
    step(tag);
  endtask

  task automatic doReset();
    idleAll();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleAll();
    modelReset();
    @(negedge clk);
    doReset();

    // R11: reset state
    op(0, 8, 0, 0, 0, 16'h0, "R11");
    checkVal("R11", "ctrl A after reset", lastRd[0], 16'h0FF0);
    op(1, 8, 0, 0, 0, 16'h0, "R11");
    checkVal("R11", "ctrl B after reset", lastRd[1], 16'h0FF0);
    checkVal("R11", "intN after reset", {14'h0, intNA, intNB}, 16'h0003);
    op(1, 4, 0, 1, 1, 16'h0, "R11");
    checkVal("R11", "mailbox after reset", lastRd[1], 16'h0000);

    // R1..R5 sweep: every port, mailbox and byte-enable combination
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 4; i++) begin
        for (int be = 1; be < 4; be++) begin
          logic [15:0] d;
          d = 16'((p * 4 + i + 1) * 16'h1357 + be * 16'h0101);
          op(p, i, 1, be[1], be[0], d, "R1");
          op(p, i, 0, 0, 1, 16'h0, "R1");
          op(p, i, 0, 1, 1, 16'h0, "R3");
          op(1 - p, 8, 0, 0, 0, 16'h0, "R2");
          op(1 - p, 4 + i, 0, 0, 1, 16'h0, "R4");
          op(1 - p, 8, 0, 0, 0, 16'h0, "R5");
          op(1 - p, 4 + i, 0, 1, 0, 16'h0, "R4");
          op(1 - p, 8, 0, 0, 0, 16'h0, "R4");
          op(p, i, 0, 1, 1, 16'h0, "R4");
        end
      end
    end

    // R6/R7/R8: masking on port B
    op(1, 8, 1, 0, 1, 16'hFFF5, "R6");
    op(1, 8, 0, 0, 0, 16'h0, "R6");
    checkVal("R6", "mask B readback", {12'h0, lastRd[1][3:0]}, 16'h0005);
    op(0, 8, 0, 0, 0, 16'h0, "R6");
    checkVal("R6", "mask A untouched", {12'h0, lastRd[0][3:0]}, 16'h0000);
    op(0, 0, 1, 1, 0, 16'hAB00, "R7");
    op(0, 1, 1, 1, 0, 16'hCD00, "R7");
    op(1, 8, 0, 0, 0, 16'h0, "R7");
    checkVal("R7", "ctrl B with masked source", lastRd[1], 16'h0CD5);
    checkVal("R8", "intN B pending", {15'h0, intNB}, 16'h0000);
    op(1, 8, 1, 0, 1, 16'h0007, "R8");
    checkVal("R8", "intN B after masking", {15'h0, intNB}, 16'h0001);
    op(1, 8, 1, 1, 0, 16'h0000, "R6");
    op(1, 8, 0, 0, 0, 16'h0, "R6");
    checkVal("R6", "ub-only ctrl write ignored", {12'h0, lastRd[1][3:0]}, 16'h0007);
    op(1, 8, 1, 0, 1, 16'h0000, "R7");
    op(1, 8, 0, 0, 0, 16'h0, "R7");
    checkVal("R7", "unmask creates no cause", lastRd[1], 16'h0CD0);
    checkVal("R8", "intN B after unmask", {15'h0, intNB}, 16'h0000);
    op(1, 4, 0, 1, 0, 16'h0, "R4");
    op(1, 5, 0, 1, 0, 16'h0, "R8");
    checkVal("R8", "intN B released", {15'h0, intNB}, 16'h0001);

    // R9: set and clear of one source in the same cycle, both directions
    for (int p = 0; p < 2; p++) begin
      op(p, 2, 1, 1, 1, 16'h5A5A, "R9");
      idleAll();
      setPort(p, 2, 1, 1, 0, 16'h6600);
      setPort(1 - p, 6, 0, 1, 0, 16'h0);
      step("R9");
      op(1 - p, 8, 0, 0, 0, 16'h0, "R9");
      checkVal("R9", "set wins over clear", {15'h0, lastRd[1-p][10]}, 16'h0000);
      op(1 - p, 6, 0, 1, 1, 16'h0, "R9");
      checkVal("R9", "mailbox data after collision", lastRd[1-p], 16'h665A);
      op(1 - p, 8, 0, 0, 0, 16'h0, "R9");
    end

    // R10: reserved offsets, peer-window writes, idle and write cycles
    for (int p = 0; p < 2; p++) begin
      for (int a = 4; a < 64; a++) begin
        if (a != 8) op(p, a, 1, 1, 1, 16'hFFFF, "R10");
      end
      for (int a = 0; a < 64; a++) op(p, a, 0, 1, 1, 16'h0, "R10");
    end
    idleAll();
    step("R10");
    checkVal("R10", "idle read", lastRd[0], 16'h0000);

    // R11: reset in the middle of activity
    op(0, 3, 1, 1, 1, 16'hBEEF, "R11");
    op(1, 8, 1, 0, 1, 16'h000A, "R11");
    doReset();
    op(1, 8, 0, 0, 0, 16'h0, "R11");
    checkVal("R11", "ctrl B after second reset", lastRd[1], 16'h0FF0);
    op(0, 3, 0, 1, 1, 16'h0, "R11");
    checkVal("R11", "mailbox cleared", lastRd[0], 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule